// File: doc/BRIEF.md
# Banked Indirect Configuration Register Port

This block puts fourteen configuration registers behind two host-visible locations. A byte-wide pointer names a storage bank (one per disk channel) and a register index, and a word-wide data location reads or writes the register the pointer names. When the pointer's auto-advance flag is set, each data-location access steps the index on to the next register. That lets software sweep a whole bank with a run of back-to-back data accesses and no pointer writes in between.

Every register's current value leaves the block on dedicated output ports. Downstream logic uses them for the channel's command and control base addresses, its general configuration, its data and command timing codes, and its read-ahead setup. Two read-ahead registers cannot be read back by software. One command bit in the read-ahead register is never stored and produces a single-cycle flush pulse instead.

Top module: `cfg_ptr_port`

## Requirements
- R1: After reset the pointer reads 0x00. In each bank, index 0 holds 0x01F0 (bank 0) or 0x0170 (bank 1), index 4 holds 0x03F6 or 0x0376, index 1 holds 0x01, index 5 holds 0xF5, index 6 holds 0xDE, and indices 2 and 3 hold zero.
- R2: A write with `bus_sel`=1 loads `bus_wdata[7:0]` into the pointer. A read with `bus_sel`=1 returns the pointer in `bus_rdata[7:0]` with zero above. Pointer bits 6..4 are kept but change nothing.
- R3: A data access (`bus_sel`=0) targets bank `ptr[3]` (0 = primary, 1 = secondary) at index `ptr[2:0]`. A write there changes only that register in that bank, and the new value shows on the matching output port in the next cycle.
- R4: Indices 0 and 4 are 16 bits wide. Indices 1, 2, 5 and 6 keep only `bus_wdata[7:0]` and read back with zero in bits 15..8.
- R5: With `ptr[7]`=1, every data access to an index 0..6 advances the index by one after the access, and index 6 wraps to 0. With `ptr[7]`=0 the pointer does not change on data accesses.
- R6: Index 7 holds no register. Writes to it have no effect, reads of it return zero, and accesses to it never advance the pointer.
- R7: Indices 2 and 3 are write-only and read as zero. Index 2 supplies read-ahead count bits 7..0, index 3 bits 1..0 supply count bits 9..8, and index 3 bit 7 drives the read-ahead enable output.
- R8: A write to index 3 with `bus_wdata[6]`=1 raises that bank's `fifo_clear` bit for exactly the cycle after the write. The bit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 1 = pointer location, 0 = data location |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle `bus_rd` is high, zero otherwise |
| ptr_value | output | 8 | Current pointer |
| cmd_base | output | NUM_CH x 16 | Command-block base address per bank (index 0) |
| ctl_base | output | NUM_CH x 16 | Control-block base address per bank (index 4) |
| gen_cfg | output | NUM_CH x 8 | General configuration byte per bank (index 1) |
| data_timing | output | NUM_CH x 8 | Data-port timing code per bank (index 5) |
| ctrl_timing | output | NUM_CH x 8 | Command-port timing code per bank (index 6) |
| ra_count | output | NUM_CH x 10 | Read-ahead count per bank |
| ra_enable | output | NUM_CH | Read-ahead enable per bank |
| fifo_clear | output | NUM_CH | One-cycle flush pulse per bank |

## Verification
The bench mixes directed sweeps with random traffic. One directed sweep walks a bank with auto-advance on, which shows whether the index wraps at 6 and whether it skips or repeats a register. Repeated reads with auto-advance off show whether the pointer moves when it should not. A pointer parked on index 7 with its spare bits set shows whether a dead index is really inert. Random traffic then interleaves pointer writes, pointer reads and data accesses across both banks. That separates bank cross-talk, width masking and the write-only read-zero rule from plain storage, and catches a flush pulse that lingers or fires on the wrong bank.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam int CFG_DATA_W = 16;
   localparam int PTR_W      = 8;
   localparam int IDX_W      = 3;
   localparam int NUM_IDX    = 7;
   localparam int MAX_CH     = 2;
   localparam int BYTE_W     = 8;
   localparam int RA_HI_W    = 2;
   localparam int RA_W       = BYTE_W + RA_HI_W;

   // pointer fields
   localparam int PTR_AUTOINC_BIT = 7;
   localparam int PTR_BANK_BIT    = 3;

   // register indices
   localparam int IDX_CMD_BASE = 0;
   localparam int IDX_GEN      = 1;
   localparam int IDX_RA_LO    = 2;
   localparam int IDX_RA_CFG   = 3;
   localparam int IDX_CTL_BASE = 4;
   localparam int IDX_DATA_TIM = 5;
   localparam int IDX_CTRL_TIM = 6;

   // read-ahead configuration fields
   localparam int RA_EN_BIT    = 7;
   localparam int FIFO_CLR_BIT = 6;

   localparam logic [CFG_DATA_W-1:0] BANK_STEP = 16'h0080;

   // storage mask for each index
   function automatic logic [CFG_DATA_W-1:0] reg_mask(input int idx);
      case (idx)
         IDX_CMD_BASE, IDX_CTL_BASE: reg_mask = 16'hFFFF;
         IDX_RA_CFG:                 reg_mask = 16'h0083;
         default:                    reg_mask = 16'h00FF;
      endcase
   endfunction

   function automatic bit reg_readable(input int idx);
      reg_readable = (idx != IDX_RA_LO) && (idx != IDX_RA_CFG);
   endfunction

   // reset value per channel and index; secondary bases sit one step lower
   function automatic logic [CFG_DATA_W-1:0] reg_default(input int ch, input int idx);
      logic [CFG_DATA_W-1:0] off;
      off = BANK_STEP * CFG_DATA_W'(ch);
      case (idx)
         IDX_CMD_BASE: reg_default = 16'h01F0 - off;
         IDX_CTL_BASE: reg_default = 16'h03F6 - off;
         IDX_GEN:      reg_default = 16'h0001;
         IDX_DATA_TIM: reg_default = 16'h00F5;
         IDX_CTRL_TIM: reg_default = 16'h00DE;
         default:      reg_default = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/cfgp_pointer.sv
module cfgp_pointer
   import cfgp_pkg::*;
#(
   parameter logic [PTR_W-1:0] RESET_PTR = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr,
   input  logic [PTR_W-1:0] ptr_wdata,
   input  logic             data_acc,
   output logic [PTR_W-1:0] ptr_q,
   output logic [IDX_W-1:0] idx,
   output logic             bank
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IDX - 1);

   if (NUM_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("cfgp_pointer: index field too narrow for register count");
   end

   logic             autoinc;
   logic             idx_live;
   logic [IDX_W-1:0] idx_next;

   assign idx      = ptr_q[IDX_W-1:0];
   assign bank     = ptr_q[PTR_BANK_BIT];
   assign autoinc  = ptr_q[PTR_AUTOINC_BIT];
   assign idx_live = (idx <= LAST_IDX);
   assign idx_next = (idx == LAST_IDX) ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= RESET_PTR;
      end else if (ptr_wr) begin
         ptr_q <= ptr_wdata;
      end else if (data_acc && autoinc && idx_live) begin
         ptr_q[IDX_W-1:0] <= idx_next;
      end
   end

endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
   import cfgp_pkg::*;
#(
   parameter int CH = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      idx,
   input  logic [CFG_DATA_W-1:0] wdata,
   output logic [CFG_DATA_W-1:0] rd_data,
   output logic [CFG_DATA_W-1:0] cmd_base,
   output logic [CFG_DATA_W-1:0] ctl_base,
   output logic [BYTE_W-1:0]     gen_cfg,
   output logic [BYTE_W-1:0]     data_timing,
   output logic [BYTE_W-1:0]     ctrl_timing,
   output logic [RA_W-1:0]       ra_count,
   output logic                  ra_enable,
   output logic                  fifo_clear
);

   if (CH < 0 || CH >= MAX_CH) begin : g_bad_ch
      $error("cfgp_bank: channel number out of range");
   end

   logic [CFG_DATA_W-1:0] reg_v   [NUM_IDX];
   logic [CFG_DATA_W-1:0] rd_part [NUM_IDX];
   logic                  clr_q;

   for (genvar i = 0; i < NUM_IDX; i++) begin : g_reg
      localparam logic [CFG_DATA_W-1:0] MASK = reg_mask(i);
      localparam logic [CFG_DATA_W-1:0] DEF  = reg_default(CH, i);
      localparam bit                    RD   = reg_readable(i);

      logic                  hit;
      logic [CFG_DATA_W-1:0] q;

      assign hit = (idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= DEF;
         end else if (wr_en && hit) begin
            q <= wdata & MASK;
         end
      end

      assign reg_v[i] = q;

      if (RD) begin : g_rd
         assign rd_part[i] = hit ? q : '0;
      end else begin : g_wo
         assign rd_part[i] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_IDX; i++) begin
         rd_data = rd_data | rd_part[i];
      end
   end

   // flush command: pulse only, never stored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_q <= 1'b0;
      end else begin
         clr_q <= wr_en && (idx == IDX_W'(IDX_RA_CFG)) && wdata[FIFO_CLR_BIT];
      end
   end

   assign cmd_base    = reg_v[IDX_CMD_BASE];
   assign ctl_base    = reg_v[IDX_CTL_BASE];
   assign gen_cfg     = reg_v[IDX_GEN][BYTE_W-1:0];
   assign data_timing = reg_v[IDX_DATA_TIM][BYTE_W-1:0];
   assign ctrl_timing = reg_v[IDX_CTRL_TIM][BYTE_W-1:0];
   assign ra_count    = {reg_v[IDX_RA_CFG][RA_HI_W-1:0], reg_v[IDX_RA_LO][BYTE_W-1:0]};
   assign ra_enable   = reg_v[IDX_RA_CFG][RA_EN_BIT];
   assign fifo_clear  = clr_q;

endmodule

// File: rtl/cfg_ptr_port.sv
module cfg_ptr_port
   import cfgp_pkg::*;
#(
   parameter int               NUM_CH    = 2,
   parameter logic [PTR_W-1:0] RESET_PTR = '0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bus_sel,
   input  logic                             bus_wr,
   input  logic                             bus_rd,
   input  logic [CFG_DATA_W-1:0]            bus_wdata,
   output logic [CFG_DATA_W-1:0]            bus_rdata,
   output logic [PTR_W-1:0]                 ptr_value,
   output logic [NUM_CH-1:0][CFG_DATA_W-1:0] cmd_base,
   output logic [NUM_CH-1:0][CFG_DATA_W-1:0] ctl_base,
   output logic [NUM_CH-1:0][BYTE_W-1:0]     gen_cfg,
   output logic [NUM_CH-1:0][BYTE_W-1:0]     data_timing,
   output logic [NUM_CH-1:0][BYTE_W-1:0]     ctrl_timing,
   output logic [NUM_CH-1:0][RA_W-1:0]       ra_count,
   output logic [NUM_CH-1:0]                 ra_enable,
   output logic [NUM_CH-1:0]                 fifo_clear
);

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_num_ch
      $error("cfg_ptr_port: NUM_CH must be 1 or 2");
   end

   logic                  ptr_wr;
   logic                  data_wr;
   logic                  data_acc;
   logic [IDX_W-1:0]      idx;
   logic                  bank;
   logic [CFG_DATA_W-1:0] bank_rd [MAX_CH];

   assign ptr_wr   = bus_sel && bus_wr;
   assign data_wr  = !bus_sel && bus_wr;
   assign data_acc = !bus_sel && (bus_wr || bus_rd);

   cfgp_pointer #(
      .RESET_PTR (RESET_PTR)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_wr    (ptr_wr),
      .ptr_wdata (bus_wdata[PTR_W-1:0]),
      .data_acc  (data_acc),
      .ptr_q     (ptr_value),
      .idx       (idx),
      .bank      (bank)
   );

   for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
      if (c < NUM_CH) begin : g_live
         logic bank_hit;
         assign bank_hit = (bank == 1'(c));

         cfgp_bank #(
            .CH (c)
         ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (data_wr && bank_hit),
            .idx         (idx),
            .wdata       (bus_wdata),
            .rd_data     (bank_rd[c]),
            .cmd_base    (cmd_base[c]),
            .ctl_base    (ctl_base[c]),
            .gen_cfg     (gen_cfg[c]),
            .data_timing (data_timing[c]),
            .ctrl_timing (ctrl_timing[c]),
            .ra_count    (ra_count[c]),
            .ra_enable   (ra_enable[c]),
            .fifo_clear  (fifo_clear[c])
         );
      end else begin : g_absent
         assign bank_rd[c] = '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_sel) begin
            bus_rdata = {{(CFG_DATA_W-PTR_W){1'b0}}, ptr_value};
         end else begin
            bus_rdata = bank_rd[bank];
         end
      end
   end

endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker
   import cfgp_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [CFG_DATA_W-1:0] bus_wdata,
   input logic [CFG_DATA_W-1:0] bus_rdata,
   input logic [PTR_W-1:0]      ptr_value,
   input logic [NUM_CH-1:0]     fifo_clear
);

   logic             dacc;
   logic [IDX_W-1:0] cidx;

   assign dacc = !bus_sel && (bus_wr || bus_rd);
   assign cidx = ptr_value[IDX_W-1:0];

   // R2: pointer write lands in the next cycle
   a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr) |=> (ptr_value == $past(bus_wdata[PTR_W-1:0])));

   // R5: auto-advance steps the index
   a_r5_autoinc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && ptr_value[PTR_AUTOINC_BIT] && cidx < 3'd6)
      |=> (ptr_value[IDX_W-1:0] == $past(cidx) + 3'd1));

   // R5: auto-advance wraps after the last register
   a_r5_autoinc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && ptr_value[PTR_AUTOINC_BIT] && cidx == 3'd6)
      |=> (ptr_value[IDX_W-1:0] == 3'd0));

   // R5: no advance with the flag clear
   a_r5_no_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && !ptr_value[PTR_AUTOINC_BIT]) |=> $stable(ptr_value));

   // R6: dead index holds the pointer and reads zero
   a_r6_idx7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dacc && cidx == 3'd7) |=> $stable(ptr_value));

   a_r6_idx7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && bus_rd && cidx == 3'd7) |-> (bus_rdata == '0));

   // R7: write-only registers read as zero
   a_r7_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel && bus_rd && (cidx == 3'd2 || cidx == 3'd3)) |-> (bus_rdata == '0));

   // R8: a flush pulse always follows a matching command write
   for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
      a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_clear[c] |-> $past(!bus_sel && bus_wr && (ptr_value[PTR_BANK_BIT] == 1'(c))
                                 && cidx == 3'd3 && bus_wdata[FIFO_CLR_BIT]));
   end

endmodule

bind cfg_ptr_port cfgp_checker #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .ptr_value  (ptr_value),
   .fifo_clear (fifo_clear)
);

// File: tb/tb_cfg_ptr_port.sv
module tb_cfg_ptr_port;

   localparam int CLK_P = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_sel = 1'b0;
   logic             bus_wr = 1'b0;
   logic             bus_rd = 1'b0;
   logic [15:0]      bus_wdata = '0;
   logic [15:0]      bus_rdata;
   logic [7:0]       ptr_value;
   logic [1:0][15:0] cmd_base, ctl_base;
   logic [1:0][7:0]  gen_cfg, data_timing, ctrl_timing;
   logic [1:0][9:0]  ra_count;
   logic [1:0]       ra_enable, fifo_clear;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [15:0] m_reg [2][7];
   logic [7:0]  m_ptr;
   logic [1:0]  m_clr;

   always #(CLK_P/2) clk = ~clk;

   cfg_ptr_port #(.NUM_CH(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ptr_value(ptr_value),
      .cmd_base(cmd_base), .ctl_base(ctl_base), .gen_cfg(gen_cfg),
      .data_timing(data_timing), .ctrl_timing(ctrl_timing), .ra_count(ra_count),
      .ra_enable(ra_enable), .fifo_clear(fifo_clear)
   );

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input bit sel);
      logic [2:0] i;
      i = m_ptr[2:0];
      if (sel) return {8'h00, m_ptr};
      if (i == 3'd7 || i == 3'd2 || i == 3'd3) return 16'h0000;
      return m_reg[m_ptr[3]][i];
   endfunction

   function automatic logic [127:0] exp_outs(input int b);
      return {m_reg[b][0], m_reg[b][1][7:0], m_reg[b][3][1:0], m_reg[b][2][7:0],
              m_reg[b][3][7], m_reg[b][4], m_reg[b][5][7:0], m_reg[b][6][7:0], m_clr[b]};
   endfunction

   task automatic check_outs(input string tag);
      for (int b = 0; b < 2; b++) begin
         check({tag, " outputs"},
               {cmd_base[b], gen_cfg[b], ra_count[b], ra_enable[b], ctl_base[b],
                data_timing[b], ctrl_timing[b], fifo_clear[b]}, exp_outs(b));
      end
      check({tag, " pointer"}, ptr_value, m_ptr);
   endtask

   task automatic model_reset();
      for (int b = 0; b < 2; b++) begin
         m_reg[b][0] = b ? 16'h0170 : 16'h01F0;
         m_reg[b][1] = 16'h0001;
         m_reg[b][2] = 16'h0000;
         m_reg[b][3] = 16'h0000;
         m_reg[b][4] = b ? 16'h0376 : 16'h03F6;
         m_reg[b][5] = 16'h00F5;
         m_reg[b][6] = 16'h00DE;
      end
      m_ptr = 8'h00;
      m_clr = 2'b00;
   endtask

   // one bus access: drive at negedge, check read before the edge, model after it
   task automatic op(input bit sel, input bit wr, input bit rd, input logic [15:0] wd,
                     input string tag);
      logic [2:0] i;
      int b;
      @(negedge clk);
      bus_sel = sel; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
      #(CLK_P/4);
      if (rd) check({tag, " read"}, bus_rdata, exp_read(sel));
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
      i = m_ptr[2:0];
      b = int'(m_ptr[3]);
      m_clr = 2'b00;
      if (sel) begin
         if (wr) m_ptr = wd[7:0];
      end else if (wr || rd) begin
         if (wr && i != 3'd7) begin
            case (i)
               3'd0, 3'd4: m_reg[b][i] = wd;
               3'd3: begin
                  m_reg[b][3] = wd & 16'h0083;
                  m_clr[b] = wd[6];
               end
               default: m_reg[b][i] = {8'h00, wd[7:0]};
            endcase
         end
         if (m_ptr[7] && i != 3'd7) m_ptr[2:0] = (i == 3'd6) ? 3'd0 : i + 3'd1;
      end
      check_outs(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int r;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check_outs("R1 reset");
      op(1'b1, 1'b0, 1'b1, 16'h0, "R1 R2 pointer reset read");

      // R5: sweep bank 0 with auto-advance, including the wrap
      op(1'b1, 1'b1, 1'b0, 16'h0080, "R2 pointer load");
      for (int k = 0; k < 8; k++) op(1'b0, 1'b0, 1'b1, 16'h0, "R1 R5 R7 sweep bank0");
      // R5: sweep bank 1
      op(1'b1, 1'b1, 1'b0, 16'h0088, "R2 pointer load bank1");
      for (int k = 0; k < 7; k++) op(1'b0, 1'b0, 1'b1, 16'h0, "R1 R5 sweep bank1");

      // R5: no advance with flag clear
      op(1'b1, 1'b1, 1'b0, 16'h0005, "R2 pointer load");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R5 hold read");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R5 hold read again");

      // R4: byte register keeps low byte
      op(1'b0, 1'b1, 1'b0, 16'h1234, "R4 byte write");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R4 byte read");

      // R8, R7: flush command and write-only fields
      op(1'b1, 1'b1, 1'b0, 16'h0003, "R2 pointer load");
      op(1'b0, 1'b1, 1'b0, 16'h00C3, "R8 flush write");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R7 R8 write-only read and pulse end");

      // R3: bank 1 write leaves bank 0 alone
      op(1'b1, 1'b1, 1'b0, 16'h0008, "R2 pointer load");
      op(1'b0, 1'b1, 1'b0, 16'hABCD, "R3 bank1 word write");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R3 R4 bank1 word read");

      // R6, R2: dead index with spare pointer bits set
      op(1'b1, 1'b1, 1'b0, 16'h00F7, "R2 pointer spare bits");
      op(1'b0, 1'b1, 1'b0, 16'h5555, "R6 index7 write");
      op(1'b0, 1'b0, 1'b1, 16'h0, "R6 index7 read");
      op(1'b1, 1'b0, 1'b1, 16'h0, "R2 R6 pointer readback");

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         r = $urandom_range(0, 9);
         if (r < 2)      op(1'b1, 1'b1, 1'b0, 16'($urandom_range(0, 255)), "R2 random ptr write");
         else if (r < 3) op(1'b1, 1'b0, 1'b1, 16'h0, "R2 random ptr read");
         else if (r < 7) op(1'b0, 1'b1, 1'b0, 16'($urandom), "R3 random data write");
         else            op(1'b0, 1'b0, 1'b1, 16'h0, "R3 random data read");
      end
      finish_run();
   end

endmodule